// File: doc/BRIEF.md
# Memory Block Move Engine

This block is a small sequencer that copies a run of bytes from one memory region to another. It uses one byte-wide memory port with synchronous single-cycle strobes. A start pulse loads a source pointer, a destination pointer, a transfer count and a width-select bit. The engine then reads one byte at the source pointer and writes it at the destination pointer. After each byte, both pointers advance by one and the count falls by one. This repeats until the count reaches zero.

The width-select bit sets how much of the count field is used. When it is clear, only the low 8 bits form the count. When it is set, the full 16 bits form the count. A zero count moves nothing. The run length is fixed at 8 overhead cycles plus 4 cycles per byte, so a controller can plan around it. The final pointers and count stay on the outputs after the run, and a host reads them there.

Top module: `blkmove_engine`

## Requirements
- R1: A start pulse sampled while idle begins a run. busy is high from the next cycle for exactly 8+4n cycles, where n is the effective count. done is a single-cycle pulse on the last busy cycle.
- R2: Each byte costs exactly one read strobe and one write strobe. The read strobe (mem_re) presents the source pointer on mem_addr. The matching write strobe (mem_we) comes two cycles later. It presents the destination pointer and carries the byte returned for that read.
- R3: After each byte, both pointers step up by one. At the end of a run, src_out equals the start source plus n and dst_out equals the start destination plus n.
- R4: The count falls by one per byte, and the loop stops when the effective count reaches zero.
- R5: A zero effective count produces no memory strobe. The run lasts 8 busy cycles with done on the eighth, and the pointers and count are left unchanged.
- R6: With wide_mode=0, only cnt_in[7:0] is the count. cnt_out[15:8] keeps the value of cnt_in[15:8], so a nonzero upper byte with a zero low byte is a zero count.
- R7: With wide_mode=1, all 16 bits form the count. For example, 16'h0100 moves 256 bytes.
- R8: Pointers are 24 bits wide and wrap modulo 2^24. 24'hFFFFFF steps to 24'h000000.
- R9: A start pulse while busy is ignored. The run in progress keeps its timing and its results.
- R10: After done, src_out, dst_out and cnt_out hold their values until the next accepted start.
- R11: mem_re and mem_we are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (taken only when idle) |
| wide_mode | input | 1 | 0: 8-bit count, 1: 16-bit count |
| src_in | input | 24 | Start source pointer |
| dst_in | input | 24 | Start destination pointer |
| cnt_in | input | 16 | Start count |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse on last busy cycle |
| src_out | output | 24 | Current/final source pointer |
| dst_out | output | 24 | Current/final destination pointer |
| cnt_out | output | 16 | Current/final count |
| mem_addr | output | 24 | Memory address |
| mem_re | output | 1 | Read strobe, data returned next cycle |
| mem_rdata | input | 8 | Read data |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |

## Verification
The bench counts clock cycles from the edge that samples start. busy is due one cycle later. done is due exactly 8+4n cycles after that edge. The final pointers are due on the first idle cycle. The bench checks every value at the falling edge of the cycle where it is due. Each read strobe must carry the next source address, and each write strobe must carry the next destination address. Destination memory is compared with a snapshot of the source bytes taken before the run. To test that a start pulse is ignored, the bench drives one during a run and expects the original cycle count and results.

// File: rtl/blkmove_pkg.sv
package blkmove_pkg;
   typedef enum logic [2:0] {
      MV_IDLE,
      MV_SETUP,
      MV_RD,
      MV_CAP,
      MV_WR,
      MV_UPD,
      MV_FIN
   } mv_state_t;
endpackage

// File: rtl/blkmove_ctrl.sv
module blkmove_ctrl
   import blkmove_pkg::*;
#(
   parameter int OVERHEAD = 8
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   input  logic      cnt_zero,
   input  logic      cnt_last,
   output mv_state_t state,
   output logic      load,
   output logic      step,
   output logic      rd_en,
   output logic      cap_en,
   output logic      wr_en,
   output logic      busy,
   output logic      done
);
   localparam int SETUP_CYC = OVERHEAD - 1;
   localparam int SC_W = (SETUP_CYC > 1) ? $clog2(SETUP_CYC) : 1;
   localparam logic [SC_W-1:0] SC_LAST = SC_W'(SETUP_CYC - 1);

   generate
      if (OVERHEAD < 2) begin : g_bad_overhead
         $error("blkmove_ctrl: OVERHEAD must be at least 2");
      end
   endgenerate

   mv_state_t      state_n;
   logic [SC_W-1:0] sc_q;

   assign load   = (state == MV_IDLE) && start;
   assign step   = (state == MV_UPD);
   assign rd_en  = (state == MV_RD);
   assign cap_en = (state == MV_CAP);
   assign wr_en  = (state == MV_WR);
   assign done   = (state == MV_FIN);
   assign busy   = (state != MV_IDLE);

   always_comb begin
      state_n = state;
      case (state)
         MV_IDLE:  if (start) state_n = MV_SETUP;
         MV_SETUP: if (sc_q == SC_LAST) state_n = cnt_zero ? MV_FIN : MV_RD;
         MV_RD:    state_n = MV_CAP;
         MV_CAP:   state_n = MV_WR;
         MV_WR:    state_n = MV_UPD;
         MV_UPD:   state_n = cnt_last ? MV_FIN : MV_RD;
         MV_FIN:   state_n = MV_IDLE;
         default:  state_n = MV_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= MV_IDLE;
         sc_q  <= '0;
      end else begin
         state <= state_n;
         if (state == MV_SETUP) sc_q <= sc_q + 1'b1;
         else                   sc_q <= '0;
      end
   end

   // R9
   start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == MV_SETUP && sc_q == '0) |-> $past(state) == MV_IDLE);

   // R1
   done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy && !done);
endmodule

// File: rtl/blkmove_regs.sv
module blkmove_regs #(
   parameter int PTR_W    = 24,
   parameter int CNT_W    = 16,
   parameter int NARROW_W = 8,
   parameter int DATA_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic              cap_en,
   input  logic              wide_in,
   input  logic [PTR_W-1:0]  src_in,
   input  logic [PTR_W-1:0]  dst_in,
   input  logic [CNT_W-1:0]  cnt_in,
   input  logic [DATA_W-1:0] rdata,
   output logic [PTR_W-1:0]  src_q,
   output logic [PTR_W-1:0]  dst_q,
   output logic [CNT_W-1:0]  cnt_q,
   output logic [DATA_W-1:0] data_q,
   output logic              cnt_zero,
   output logic              cnt_last
);
   localparam logic [PTR_W-1:0]    PTR_ONE = PTR_W'(1);
   localparam logic [CNT_W-1:0]    CNT_ONE = CNT_W'(1);
   localparam logic [NARROW_W-1:0] NAR_ONE = NARROW_W'(1);

   logic             wide_q;
   logic [CNT_W-1:0] eff_cnt;
   logic [CNT_W-1:0] cnt_dec;

   generate
      if (NARROW_W < 1 || NARROW_W > CNT_W) begin : g_bad_width
         $error("blkmove_regs: NARROW_W must be within 1..CNT_W");
      end
      if (CNT_W > NARROW_W) begin : g_split
         logic [NARROW_W-1:0] lo_dec;
         assign lo_dec  = cnt_q[NARROW_W-1:0] - NAR_ONE;
         assign eff_cnt = wide_q ? cnt_q
                                 : {{(CNT_W-NARROW_W){1'b0}}, cnt_q[NARROW_W-1:0]};
         assign cnt_dec = wide_q ? (cnt_q - CNT_ONE)
                                 : {cnt_q[CNT_W-1:NARROW_W], lo_dec};
      end else begin : g_single
         assign eff_cnt = cnt_q;
         assign cnt_dec = cnt_q - CNT_ONE;
      end
   endgenerate

   assign cnt_zero = (eff_cnt == '0);
   assign cnt_last = (eff_cnt == CNT_ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= '0;
         dst_q  <= '0;
         cnt_q  <= '0;
         data_q <= '0;
         wide_q <= 1'b0;
      end else if (load) begin
         src_q  <= src_in;
         dst_q  <= dst_in;
         cnt_q  <= cnt_in;
         wide_q <= wide_in;
      end else begin
         if (cap_en) data_q <= rdata;
         if (step) begin
            src_q <= src_q + PTR_ONE;
            dst_q <= dst_q + PTR_ONE;
            cnt_q <= cnt_dec;
         end
      end
   end

   // R4
   no_step_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> !cnt_zero);

   // R3
   ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (src_q - $past(src_q)) == PTR_ONE && (dst_q - $past(dst_q)) == PTR_ONE);

   // R6
   upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !wide_q) |=> cnt_q[CNT_W-1:NARROW_W] == $past(cnt_q[CNT_W-1:NARROW_W]));
endmodule

// File: rtl/blkmove_engine.sv
module blkmove_engine
   import blkmove_pkg::*;
#(
   parameter int PTR_W    = 24,
   parameter int CNT_W    = 16,
   parameter int NARROW_W = 8,
   parameter int DATA_W   = 8,
   parameter int OVERHEAD = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              wide_mode,
   input  logic [PTR_W-1:0]  src_in,
   input  logic [PTR_W-1:0]  dst_in,
   input  logic [CNT_W-1:0]  cnt_in,
   output logic              busy,
   output logic              done,
   output logic [PTR_W-1:0]  src_out,
   output logic [PTR_W-1:0]  dst_out,
   output logic [CNT_W-1:0]  cnt_out,
   output logic [PTR_W-1:0]  mem_addr,
   output logic              mem_re,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata
);
   mv_state_t   state;
   logic        load, step, rd_en, cap_en, wr_en;
   logic        cnt_zero, cnt_last;
   logic [DATA_W-1:0] data_q;

   blkmove_ctrl #(.OVERHEAD(OVERHEAD)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .cnt_zero (cnt_zero),
      .cnt_last (cnt_last),
      .state    (state),
      .load     (load),
      .step     (step),
      .rd_en    (rd_en),
      .cap_en   (cap_en),
      .wr_en    (wr_en),
      .busy     (busy),
      .done     (done)
   );

   blkmove_regs #(
      .PTR_W    (PTR_W),
      .CNT_W    (CNT_W),
      .NARROW_W (NARROW_W),
      .DATA_W   (DATA_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .step     (step),
      .cap_en   (cap_en),
      .wide_in  (wide_mode),
      .src_in   (src_in),
      .dst_in   (dst_in),
      .cnt_in   (cnt_in),
      .rdata    (mem_rdata),
      .src_q    (src_out),
      .dst_q    (dst_out),
      .cnt_q    (cnt_out),
      .data_q   (data_q),
      .cnt_zero (cnt_zero),
      .cnt_last (cnt_last)
   );

   assign mem_re    = rd_en;
   assign mem_we    = wr_en;
   assign mem_wdata = data_q;
   assign mem_addr  = wr_en ? dst_out : src_out;

   // R11
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_re && mem_we));

   // R2
   write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we) |-> $past(mem_re, 2));

   // R10
   hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(src_out) && $stable(dst_out) && $stable(cnt_out));
endmodule

// File: tb/blkmove_engine_bench.sv
module blkmove_engine_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        wide_mode = 1'b0;
   logic [23:0] src_in = '0, dst_in = '0;
   logic [15:0] cnt_in = '0;
   logic        busy, done, mem_re, mem_we;
   logic [23:0] src_out, dst_out, mem_addr;
   logic [15:0] cnt_out;
   logic [7:0]  mem_rdata = '0, mem_wdata;

   logic [7:0]  mem  [0:4095];
   logic [7:0]  snap [0:4095];

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   blkmove_engine u_blkmove_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .wide_mode(wide_mode),
      .src_in(src_in), .dst_in(dst_in), .cnt_in(cnt_in),
      .busy(busy), .done(done), .src_out(src_out), .dst_out(dst_out),
      .cnt_out(cnt_out), .mem_addr(mem_addr), .mem_re(mem_re),
      .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_wdata(mem_wdata)
   );

   always @(posedge clk) begin
      if (mem_re) mem_rdata <= mem[mem_addr[11:0]];
      if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_move(input logic [23:0] s, input logic [23:0] d,
                           input logic [15:0] c, input logic w, input bit poke);
      int n, cyc, done_cnt, done_at, re_n, we_n, bad_addr, both, bad_mem;
      logic [15:0] exp_cnt;
      n = w ? int'(c) : int'(c[7:0]);
      exp_cnt = w ? 16'h0000 : {c[15:8], 8'h00};
      for (int i = 0; i < 4096; i++) snap[i] = mem[i];
      cyc = 0; done_cnt = 0; done_at = 0; re_n = 0; we_n = 0;
      bad_addr = 0; both = 0; bad_mem = 0;
      @(negedge clk);
      src_in = s; dst_in = d; cnt_in = c; wide_mode = w; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      src_in = 24'h555555; dst_in = 24'h666666; cnt_in = 16'h0003; wide_mode = ~w;
      while (busy && cyc < 5000) begin
         cyc++;
         if (done) begin done_cnt++; done_at = cyc; end
         if (mem_re && mem_we) both++;
         if (mem_re) begin
            if (mem_addr != s + 24'(re_n)) bad_addr++;
            re_n++;
         end
         if (mem_we) begin
            if (mem_addr != d + 24'(we_n)) bad_addr++;
            we_n++;
         end
         if (poke && cyc == 5) start = 1'b1;
         if (poke && cyc == 6) start = 1'b0;
         @(negedge clk);
      end
      start = 1'b0;
      for (int k = 0; k < n; k++) begin
         logic [23:0] sa, da;
         sa = s + 24'(k);
         da = d + 24'(k);
         if (mem[da[11:0]] != snap[sa[11:0]]) bad_mem++;
      end
      // R1 R9: busy length and done placement
      chk(cyc == 8 + 4 * n, poke ? "R9 busy length" : "R1 busy length", cyc, 8 + 4 * n);
      chk(done_cnt == 1 && done_at == cyc, "R1 done pulse", done_at, cyc);
      // R2 R5: strobe counts and addresses
      chk(re_n == n && we_n == n, (n == 0) ? "R5 no strobes" : "R2 strobe count", we_n, n);
      chk(bad_addr == 0 && bad_mem == 0, "R2 addresses and data", bad_addr + bad_mem, 0);
      chk(both == 0, "R11 strobe overlap", both, 0);
      // R3 R8: final pointers
      chk(src_out == s + 24'(n) && dst_out == d + 24'(n), "R3 final pointers", src_out, s + 24'(n));
      // R4 R6: final count
      chk(cnt_out == exp_cnt, w ? "R4 final count" : "R6 upper byte kept", cnt_out, exp_cnt);
   endtask

   task automatic test_hold();
      logic [23:0] s0, d0;
      logic [15:0] c0;
      s0 = src_out; d0 = dst_out; c0 = cnt_out;
      src_in = 24'h123456; cnt_in = 16'h0042;
      repeat (10) @(negedge clk);
      // R10
      chk(src_out == s0 && dst_out == d0 && cnt_out == c0 && !busy, "R10 hold after done", src_out, s0);
   endtask

   initial begin
      #(200000 * 4);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3);
      repeat (3) @(negedge clk);
      // reset state
      chk(!busy && !done && !mem_re && !mem_we, "R1 reset idle", busy, 0);
      rst_n = 1'b1;
      @(negedge clk);
      run_move(24'h000020, 24'h000B00, 16'h0005, 1'b1, 1'b0);   // R4 word small
      run_move(24'h000010, 24'h000A00, 16'h1203, 1'b0, 1'b0);   // R6 byte mode
      run_move(24'h000100, 24'h000800, 16'h0100, 1'b1, 1'b0);   // R7 256 bytes
      chk(src_out == 24'h000200, "R7 word count 0x0100", src_out, 24'h000200);
      run_move(24'h000300, 24'h000900, 16'h0000, 1'b1, 1'b0);   // R5 zero word
      run_move(24'h000310, 24'h000910, 16'h4500, 1'b0, 1'b0);   // R5 R6 zero low byte
      run_move(24'hFFFFFE, 24'h000300, 16'h0004, 1'b1, 1'b0);   // R8 wrap
      chk(src_out == 24'h000002, "R8 pointer wrap", src_out, 24'h000002);
      run_move(24'h000040, 24'h000C00, 16'h0006, 1'b1, 1'b1);   // R9 start while busy
      test_hold();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule